// File: doc/BRIEF.md
# Multi-Bank Flash Operation Controller

This block sequences word program and block erase operations on a word-organised flash array divided into banks, and it enforces the rules for running one operation while reading elsewhere. It takes already-decoded commands (read, program word, erase block, suspend, resume, clear status) with a word address. It records which bank owns the running operation, so reads aimed at any other bank return array contents without waiting. A read aimed at the owning bank returns the status byte instead.

An erase can be suspended. While it is suspended, a word may be programmed in any other block, and that program may itself be suspended so that reads can proceed. Resume always restarts the innermost suspended operation first. Operation time comes from a cycle-count model: the durations of program and erase are supplied as inputs, and a small storage model stands in for the cells. Programming can only clear bits, and erasing returns a whole block to all ones. After reset every block is erased, nothing is running, and reads return array data at once.

Address layout with the default parameters: 10-bit word address, bank = addr[9:8] (4 banks), block = addr[9:6] (16 blocks of 64 words).

Top module: `flash_op_ctrl`

## Requirements
- R1: After reset, ready_o is 1, status_o is 8'h80, and a READ returns 16'hFFFF with rd_status_o 0; read results appear with rd_valid_o 1 in the cycle after the command is accepted.
- R2: An accepted PROGRAM holds ready_o low for exactly prog_cycles_i cycles (a value of 0 counts as 1), then the word becomes its old value AND the command data, and status bit 0 (done) is set.
- R3: An accepted ERASE holds ready_o low for exactly erase_cycles_i cycles (0 counts as 1), then all 64 words of the addressed block read 16'hFFFF; words in other blocks keep their values.
- R4: A PROGRAM or ERASE that arrives while an operation runs, a PROGRAM or ERASE while a program is suspended, or an ERASE while an erase is suspended, is rejected: no operation starts, the array is unchanged, and status bit 5 (sequence error) is set.
- R5: A READ to a bank other than busy_bank_o while an operation runs returns array data with rd_status_o 0.
- R6: A READ to the bank in busy_bank_o while an operation runs returns {8'h00, status} with rd_status_o 1.
- R7: SUSPEND during an erase stops its timer, sets ready_o and status bit 6; RESUME continues the erase for the cycles still owed, so the busy cycles before and after the suspension add up to erase_cycles_i.
- R8: SUSPEND during a program sets ready_o and status bit 2; reads in other blocks return array data; RESUME finishes the remaining program cycles and the word is written.
- R9: A PROGRAM addressed to the block whose erase is suspended sets status bit 4 (program error), does not start, and writes nothing.
- R10: SUSPEND when nothing runs and RESUME when nothing is suspended are ignored: status and array contents stay unchanged.
- R11: CLEAR zeroes status bits 5, 4 and 0 and leaves the others.
- R12: A READ to a block that holds a suspended program or erase returns {8'h00, status} with rd_status_o 1.
- R13: Status bit 7 equals ready_o, and done (bit 0) is cleared when a new program or erase is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | 1 read, 2 program, 3 erase, 4 suspend, 5 resume, 6 clear status |
| cmd_addr_i | input | ADDR_W | Word address |
| cmd_data_i | input | DATA_W | Program data |
| prog_cycles_i | input | CNT_W | Program duration in cycles |
| erase_cycles_i | input | CNT_W | Erase duration in cycles |
| ready_o | output | 1 | No operation executing |
| busy_bank_o | output | BANK_W | Bank owning the running operation |
| status_o | output | 8 | Status byte |
| rd_valid_o | output | 1 | Read result valid |
| rd_status_o | output | 1 | Read result is the status byte |
| rd_data_o | output | DATA_W | Read result |

## Verification
The hardest state to reach is the nested one: an erase suspended part-way, a program running in another block of the same bank, and reads aimed at the suspended block, the running bank and a third bank, all in the same window. The bench programs the target block first so that an erase has something to clear. It suspends the erase after a known number of cycles, fires an illegal program into the suspended block and an illegal erase, runs a legal program beside it, and then resumes. It compares the busy cycles left after the resume with the duration minus the cycles already spent.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5,
        OP_CLEAR  = 3'd6
    } flash_cmd_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_PROG  = 2'd1,
        RUN_ERASE = 2'd2
    } run_kind_e;

    localparam int STAT_W    = 8;
    localparam int ST_READY  = 7;
    localparam int ST_ESUSP  = 6;
    localparam int ST_SEQERR = 5;
    localparam int ST_PERR   = 4;
    localparam int ST_PSUSP  = 2;
    localparam int ST_DONE   = 0;

endpackage

// File: rtl/flash_addr_map.sv
module flash_addr_map #(
    parameter int ADDR_W = 10,
    parameter int BANK_W = 2,
    parameter int BLK_W  = 6
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [BANK_W-1:0]       bank_o,
    output logic [ADDR_W-BLK_W-1:0] block_o
);
    // bank sits in the top address bits, block index above the word offset
    assign bank_o  = addr_i[ADDR_W-1 -: BANK_W];
    assign block_o = addr_i[ADDR_W-1:BLK_W];
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = run_i && (cnt_q == CNT_W'(1));

    AST_TIMER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q != '0); // R2

endmodule

// File: rtl/flash_cell_model.sv
module flash_cell_model #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [DATA_W-1:0]       rd_data_o,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic                    er_en_i,
    input  logic [ADDR_W-BLK_W-1:0] er_blk_i
);
    localparam int WORDS     = 1 << ADDR_W;
    localparam int BLK_WORDS = 1 << BLK_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [WORDS-1:0]  used_d, used_q;
    logic [DATA_W-1:0] wr_old, wr_merged;

    // a word with its used flag clear reads as erased (all ones)
    assign rd_data_o = used_q[rd_addr_i] ? mem_q[rd_addr_i] : '1;
    assign wr_old    = used_q[wr_addr_i] ? mem_q[wr_addr_i] : '1;
    assign wr_merged = wr_old & wr_data_i;

    always_comb begin
        used_d = used_q;
        if (er_en_i) begin
            for (int i = 0; i < BLK_WORDS; i++) begin
                used_d[{er_blk_i, BLK_W'(i)}] = 1'b0;
            end
        end
        if (wr_en_i) begin
            used_d[wr_addr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            used_q <= used_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_merged;
        end
    end

    AST_CELL_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && er_en_i)); // R3

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_op_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int BANK_W = 2,
    parameter int BLK_W  = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic [CNT_W-1:0]  prog_cycles_i,
    input  logic [CNT_W-1:0]  erase_cycles_i,
    output logic              ready_o,
    output logic [BANK_W-1:0] busy_bank_o,
    output logic [7:0]        status_o,
    output logic              rd_valid_o,
    output logic              rd_status_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int BLKID_W = ADDR_W - BLK_W;

    typedef struct packed {
        run_kind_e         run;
        logic [ADDR_W-1:0] run_addr;
        logic [DATA_W-1:0] run_data;
        logic              esus;
        logic [ADDR_W-1:0] esus_addr;
        logic [CNT_W-1:0]  esus_cnt;
        logic              psus;
        logic [ADDR_W-1:0] psus_addr;
        logic [DATA_W-1:0] psus_data;
        logic [CNT_W-1:0]  psus_cnt;
        logic              seq_err;
        logic              prog_err;
        logic              done;
        logic              rd_valid;
        logic              rd_stat;
        logic [DATA_W-1:0] rd_data;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    flash_cmd_e         cmd_op;
    logic [BANK_W-1:0]  cmd_bank, run_bank, esus_bank_unused, psus_bank_unused;
    logic [BLKID_W-1:0] cmd_blk, run_blk, esus_blk, psus_blk;
    logic [CNT_W-1:0]   tmr_cnt, tmr_val;
    logic               tmr_load, tmr_run, tmr_expire;
    logic               cell_wr, cell_er;
    logic [DATA_W-1:0]  cell_rd;
    logic               running;
    logic [STAT_W-1:0]  status_w;

    assign cmd_op = flash_cmd_e'(cmd_op_i);

    flash_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_map_cmd (
        .addr_i(cmd_addr_i), .bank_o(cmd_bank), .block_o(cmd_blk));
    flash_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_map_run (
        .addr_i(ctl_q.run_addr), .bank_o(run_bank), .block_o(run_blk));
    flash_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_map_esus (
        .addr_i(ctl_q.esus_addr), .bank_o(esus_bank_unused), .block_o(esus_blk));
    flash_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_map_psus (
        .addr_i(ctl_q.psus_addr), .bank_o(psus_bank_unused), .block_o(psus_blk));

    flash_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load_i(tmr_load), .load_val_i(tmr_val), .run_i(tmr_run),
        .cnt_o(tmr_cnt), .expire_o(tmr_expire));

    flash_cell_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_cells (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_i(cmd_addr_i), .rd_data_o(cell_rd),
        .wr_en_i(cell_wr), .wr_addr_i(ctl_q.run_addr), .wr_data_i(ctl_q.run_data),
        .er_en_i(cell_er), .er_blk_i(run_blk));

    function automatic logic [CNT_W-1:0] dur(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    assign running = (ctl_q.run != RUN_IDLE);
    assign tmr_run = running;

    always_comb begin
        status_w            = '0;
        status_w[ST_READY]  = !running;
        status_w[ST_ESUSP]  = ctl_q.esus;
        status_w[ST_SEQERR] = ctl_q.seq_err;
        status_w[ST_PERR]   = ctl_q.prog_err;
        status_w[ST_PSUSP]  = ctl_q.psus;
        status_w[ST_DONE]   = ctl_q.done;
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.rd_stat  = 1'b0;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        cell_wr        = 1'b0;
        cell_er        = 1'b0;

        // completion of the executing operation
        if (tmr_expire) begin
            if (ctl_q.run == RUN_PROG) begin
                cell_wr = 1'b1;
            end else begin
                cell_er = 1'b1;
            end
            ctl_d.run  = RUN_IDLE;
            ctl_d.done = 1'b1;
        end

        if (cmd_valid_i) begin
            unique case (cmd_op)
                OP_READ: begin
                    ctl_d.rd_valid = 1'b1;
                    if ((running && cmd_bank == run_bank) ||
                        (ctl_q.esus && cmd_blk == esus_blk) ||
                        (ctl_q.psus && cmd_blk == psus_blk)) begin
                        ctl_d.rd_stat = 1'b1;
                        ctl_d.rd_data = DATA_W'(status_w);
                    end else begin
                        ctl_d.rd_data = cell_rd;
                    end
                end
                OP_PROG: begin
                    if (ctl_d.run != RUN_IDLE || ctl_q.psus) begin
                        ctl_d.seq_err = 1'b1;
                    end else if (ctl_q.esus && cmd_blk == esus_blk) begin
                        ctl_d.prog_err = 1'b1;
                    end else begin
                        ctl_d.run      = RUN_PROG;
                        ctl_d.run_addr = cmd_addr_i;
                        ctl_d.run_data = cmd_data_i;
                        ctl_d.done     = 1'b0;
                        tmr_load       = 1'b1;
                        tmr_val        = dur(prog_cycles_i);
                    end
                end
                OP_ERASE: begin
                    if (ctl_d.run != RUN_IDLE || ctl_q.psus || ctl_q.esus) begin
                        ctl_d.seq_err = 1'b1;
                    end else begin
                        ctl_d.run      = RUN_ERASE;
                        ctl_d.run_addr = cmd_addr_i;
                        ctl_d.done     = 1'b0;
                        tmr_load       = 1'b1;
                        tmr_val        = dur(erase_cycles_i);
                    end
                end
                OP_SUSP: begin
                    // a suspend that meets the final cycle loses to completion
                    if (running && !tmr_expire) begin
                        ctl_d.run = RUN_IDLE;
                        if (ctl_q.run == RUN_PROG) begin
                            ctl_d.psus      = 1'b1;
                            ctl_d.psus_addr = ctl_q.run_addr;
                            ctl_d.psus_data = ctl_q.run_data;
                            ctl_d.psus_cnt  = tmr_cnt - CNT_W'(1);
                        end else begin
                            ctl_d.esus      = 1'b1;
                            ctl_d.esus_addr = ctl_q.run_addr;
                            ctl_d.esus_cnt  = tmr_cnt - CNT_W'(1);
                        end
                    end
                end
                OP_RESUME: begin
                    if (ctl_d.run == RUN_IDLE) begin
                        if (ctl_q.psus) begin
                            ctl_d.run      = RUN_PROG;
                            ctl_d.run_addr = ctl_q.psus_addr;
                            ctl_d.run_data = ctl_q.psus_data;
                            ctl_d.psus     = 1'b0;
                            tmr_load       = 1'b1;
                            tmr_val        = ctl_q.psus_cnt;
                        end else if (ctl_q.esus) begin
                            ctl_d.run      = RUN_ERASE;
                            ctl_d.run_addr = ctl_q.esus_addr;
                            ctl_d.esus     = 1'b0;
                            tmr_load       = 1'b1;
                            tmr_val        = ctl_q.esus_cnt;
                        end
                    end
                end
                OP_CLEAR: begin
                    ctl_d.seq_err  = 1'b0;
                    ctl_d.prog_err = 1'b0;
                    ctl_d.done     = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready_o     = !running;
    assign busy_bank_o = run_bank;
    assign status_o    = status_w;
    assign rd_valid_o  = ctl_q.rd_valid;
    assign rd_status_o = ctl_q.rd_stat;
    assign rd_data_o   = ctl_q.rd_data;

    AST_REJECT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op == OP_ERASE && running && !tmr_expire)
        |=> status_o[ST_SEQERR]); // R4

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.psus |-> ready_o); // R4

    AST_READ_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op == OP_READ && !ready_o && cmd_bank != busy_bank_o
         && !ctl_q.esus && !ctl_q.psus)
        |=> rd_valid_o && !rd_status_o); // R5

    AST_READ_BUSY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op == OP_READ && !ready_o && cmd_bank == busy_bank_o)
        |=> rd_valid_o && rd_status_o && !rd_data_o[ST_READY]); // R6

    AST_PERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op == OP_PROG && ready_o && ctl_q.esus && !ctl_q.psus
         && cmd_blk == esus_blk)
        |=> ready_o && status_o[ST_PERR]); // R9

    AST_IDLE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op == OP_SUSP && ready_o && !ctl_q.esus && !ctl_q.psus)
        |=> $stable(status_o)); // R10

endmodule

// File: tb/sim_flash_op_ctrl.sv
module sim_flash_op_ctrl;
    import flash_op_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [9:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] prog_cycles = 16'd4;
    logic [15:0] erase_cycles = 16'd8;
    logic        ready;
    logic [1:0]  busy_bank;
    logic [7:0]  status;
    logic        rd_valid, rd_status;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_op_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
        .cmd_data_i(cmd_data), .prog_cycles_i(prog_cycles), .erase_cycles_i(erase_cycles),
        .ready_o(ready), .busy_bank_o(busy_bank), .status_o(status),
        .rd_valid_o(rd_valid), .rd_status_o(rd_status), .rd_data_o(rd_data));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, accepted at the next rising edge; returns at the falling edge after it
    task automatic do_cmd(input logic [2:0] op, input logic [9:0] addr, input logic [15:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic rd_word(input string req, input logic [9:0] addr,
                           input logic [15:0] exp_data, input logic exp_stat);
        do_cmd(OP_READ, addr, 16'h0);
        chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({req, " rd_status"}, 32'(rd_status), 32'(exp_stat));
        chk({req, " rd_data"}, 32'(rd_data), 32'(exp_data));
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 status", 32'(status), 32'h80);
        rd_word("R1 erased read", 10'h000, 16'hFFFF, 1'b0);
    endtask

    task automatic t_program;
        int n;
        prog_cycles = 16'd6;
        do_cmd(OP_PROG, 10'h012, 16'h1234);
        chk("R2 busy", 32'(ready), 32'd0);
        chk("R13 busy status", 32'(status), 32'h00);
        busy_len(n);
        chk("R2 program cycles", 32'(n), 32'd6);
        chk("R2 done status", 32'(status), 32'h81);
        rd_word("R2 word", 10'h012, 16'h1234, 1'b0);
        prog_cycles = 16'd0;
        do_cmd(OP_PROG, 10'h012, 16'hFF0F);
        busy_len(n);
        chk("R2 zero duration", 32'(n), 32'd1);
        rd_word("R2 and-merge", 10'h012, 16'h1204, 1'b0);
    endtask

    task automatic t_erase;
        int n;
        prog_cycles = 16'd2;
        do_cmd(OP_PROG, 10'h150, 16'hABCD); busy_len(n);
        do_cmd(OP_PROG, 10'h180, 16'h5555); busy_len(n);
        erase_cycles = 16'd8;
        do_cmd(OP_ERASE, 10'h155, 16'h0);
        busy_len(n);
        chk("R3 erase cycles", 32'(n), 32'd8);
        rd_word("R3 erased word", 10'h150, 16'hFFFF, 1'b0);
        rd_word("R3 neighbour block kept", 10'h180, 16'h5555, 1'b0);
    endtask

    task automatic t_dual_read;
        int n;
        prog_cycles = 16'd10;
        do_cmd(OP_PROG, 10'h013, 16'h8001);
        chk("R6 busy bank", 32'(busy_bank), 32'd0);
        rd_word("R5 other bank", 10'h180, 16'h5555, 1'b0);
        rd_word("R6 busy bank status", 10'h012, 16'h0000, 1'b1);
        busy_len(n);
        rd_word("R2 dual program word", 10'h013, 16'h8001, 1'b0);
    endtask

    task automatic t_reject;
        int n;
        erase_cycles = 16'd12;
        do_cmd(OP_ERASE, 10'h300, 16'h0);
        do_cmd(OP_PROG, 10'h100, 16'h0000);
        do_cmd(OP_ERASE, 10'h180, 16'h0);
        chk("R4 seq error while busy", 32'(status), 32'h20);
        rd_word("R5 read during erase", 10'h180, 16'h5555, 1'b0);
        busy_len(n);
        chk("R4 status after", 32'(status), 32'hA1);
        rd_word("R4 rejected erase kept data", 10'h180, 16'h5555, 1'b0);
        rd_word("R4 rejected program wrote nothing", 10'h100, 16'hFFFF, 1'b0);
        do_cmd(OP_CLEAR, 10'h0, 16'h0);
        chk("R11 clear", 32'(status), 32'h80);
    endtask

    task automatic t_erase_suspend;
        int n;
        prog_cycles = 16'd2;
        do_cmd(OP_PROG, 10'h2C0, 16'h0F0F); busy_len(n);
        erase_cycles = 16'd20;
        do_cmd(OP_ERASE, 10'h2C0, 16'h0);
        repeat (3) @(negedge clk);
        do_cmd(OP_SUSP, 10'h0, 16'h0); // accepted 5 cycles after the erase
        chk("R7 ready on suspend", 32'(ready), 32'd1);
        chk("R7 suspend status", 32'(status), 32'hC0);
        do_cmd(OP_PROG, 10'h2C4, 16'h0000);
        chk("R9 program error", 32'(status), 32'hD0);
        chk("R9 not started", 32'(ready), 32'd1);
        rd_word("R12 suspended block", 10'h2C4, 16'h00D0, 1'b1);
        do_cmd(OP_CLEAR, 10'h0, 16'h0);
        chk("R11 clear keeps suspend", 32'(status), 32'hC0);
        prog_cycles = 16'd3;
        do_cmd(OP_PROG, 10'h240, 16'h00FF);
        rd_word("R5 third bank during nested program", 10'h180, 16'h5555, 1'b0);
        do_cmd(OP_ERASE, 10'h000, 16'h0);
        busy_len(n);
        chk("R4 erase rejected while erase suspended", 32'(status), 32'hE1);
        rd_word("R8 nested program word", 10'h240, 16'h00FF, 1'b0);
        do_cmd(OP_CLEAR, 10'h0, 16'h0);
        do_cmd(OP_RESUME, 10'h0, 16'h0);
        chk("R7 resumed busy", 32'(ready), 32'd0);
        busy_len(n);
        chk("R7 remaining erase cycles", 32'(n), 32'd15);
        chk("R7 final status", 32'(status), 32'h81);
        rd_word("R7 erase finished", 10'h2C0, 16'hFFFF, 1'b0);
        rd_word("R9 no write in suspended block", 10'h2C4, 16'hFFFF, 1'b0);
        rd_word("R3 nested program survives", 10'h240, 16'h00FF, 1'b0);
    endtask

    task automatic t_prog_suspend;
        int n;
        prog_cycles = 16'd10;
        do_cmd(OP_PROG, 10'h020, 16'h3C3C);
        do_cmd(OP_SUSP, 10'h0, 16'h0); // accepted 2 cycles after the program
        chk("R8 suspend status", 32'(status), 32'h84);
        rd_word("R12 suspended program block", 10'h012, 16'h0084, 1'b1);
        rd_word("R8 other block", 10'h150, 16'hFFFF, 1'b0);
        do_cmd(OP_PROG, 10'h100, 16'h0000);
        chk("R4 program while suspended", 32'(status), 32'hA4);
        do_cmd(OP_CLEAR, 10'h0, 16'h0);
        do_cmd(OP_RESUME, 10'h0, 16'h0);
        busy_len(n);
        chk("R8 remaining program cycles", 32'(n), 32'd8);
        rd_word("R8 word written", 10'h020, 16'h3C3C, 1'b0);
        chk("R13 done", 32'(status), 32'h81);
    endtask

    task automatic t_ignored;
        do_cmd(OP_SUSP, 10'h0, 16'h0);
        chk("R10 idle suspend", 32'(status), 32'h81);
        do_cmd(OP_RESUME, 10'h0, 16'h0);
        chk("R10 idle resume", 32'(status), 32'h81);
        chk("R10 still ready", 32'(ready), 32'd1);
        rd_word("R10 array unchanged", 10'h020, 16'h3C3C, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_dual_read();
        t_reject();
        t_erase_suspend();
        t_prog_suspend();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule